// File: doc/BRIEF.md
# Coherent Snapshot Pulse Counter Bank

This block counts pulses on sixteen independent digital inputs. Each input goes through its own two-flop synchroniser and a rising-edge detector, and each detected edge advances a per-channel counter. Beside the channels runs a slow timestamp counter. A prescaler divides the system clock down to a one-cycle enable at the timestamp rate, which is nominally 1 kHz. Pulses may arrive at up to 1 MHz and last about 500 ns each, which is several system clock periods long.

A single latch strobe copies every channel count and the timestamp into shadow registers on the same clock edge. Host logic then reads any shadow register by index while the live counters keep running. The shadow registers only change on the next strobe, so each readout is a consistent picture of all channels at one instant.

Top module: `pulse_snap_bank`

## Requirements
- R1: Each of the NUM_CH channels adds exactly one to its own live count for each low-to-high transition of its input, provided the input stays high and then low for at least two clock cycles each. Other channels are not affected.
- R2: A live channel count changes by at most one per clock cycle.
- R3: Live counts and the timestamp wrap from all-ones to zero, with no saturation.
- R4: When latch_req is high at a rising clock edge, every shadow count and the shadow timestamp take the live values of that cycle together. At all other edges the shadow registers keep their values.
- R5: Live counters keep counting through a latch and after it. A later latch shows the counts accumulated since reset.
- R6: The timestamp advances by exactly one every TICK_DIV clock cycles. It does not change in any other cycle.
- R7: A synchronous active-low reset clears all live counts, the timestamp, the prescaler and all shadow registers to zero.
- R8: rd_data is combinational from rd_idx. Index values 0 to NUM_CH-1 select that channel's shadow count. Index NUM_CH (16 by default) selects the shadow timestamp. Any larger index returns zero.
- R9: An input that stays high for many cycles is counted once. No further counts are added while it remains high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | NUM_CH | Asynchronous pulse inputs, one bit per channel |
| latch_req | input | 1 | One-cycle strobe that captures all live values into the shadow registers |
| rd_idx | input | IDX_W | Shadow register select (0..NUM_CH-1 channel, NUM_CH timestamp) |
| rd_data | output | DATA_W | Selected shadow register value |

## Verification
On every cycle, the assertions check the following: each live count steps by zero or one, with wrap; the timestamp moves only on a prescaler tick; the shadow registers are stable without a strobe and equal the previous live values after one; reset clears state; and the read mux selects correctly at the timestamp index and above it. Only the bench scenarios can show the rest. These are that one input pulse produces one count through the synchroniser, that a held level counts once, and that counting carries on across latches. They also cover the exact tick spacing seen at the read port and the full wrap of a count through many real pulses.

// File: rtl/pcnt_pkg.sv
// Shared constants for the pulse counter bank.
// Assumes: nothing beyond standard SystemVerilog.
package pcnt_pkg;
    // Number of flops in the input synchroniser chain (before edge history).
    localparam int SYNC_STAGES = 2;

    // Read index width for a bank of n channels plus one timestamp slot.
    function automatic int idx_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/pcnt_edge_chan.sv
// One counting channel: two-flop synchroniser, rising-edge detect, wrapping counter.
// Assumes: input pulses are high and low for at least two clk cycles each.
module pcnt_edge_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_raw,
    output logic [CNT_W-1:0] count
);
    import pcnt_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;
    logic                   rise;

    // Synchronise the asynchronous input and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pulse_raw};
            hist_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // A rising edge is a synchronised high that was low one cycle earlier.
    always_comb begin
        rise = sync_q[SYNC_STAGES-1] & ~hist_q;
    end

    // Count detected edges; natural wrap at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (rise)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/pcnt_timebase.sv
// Prescaler and free-running timestamp counter.
// Assumes: DIV >= 2; one tick is emitted every DIV clk cycles.
module pcnt_timebase #(
    parameter int DIV  = 50000,
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            tick,
    output logic [TS_W-1:0] ts
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] div_q;

    // Tick on the last count of each prescaler period.
    always_comb begin
        tick = (div_q == PW'(DIV - 1));
    end

    // Prescaler counts 0..DIV-1 and restarts.
    always_ff @(posedge clk) begin
        if (!rst_n || tick)
            div_q <= '0;
        else
            div_q <= div_q + PW'(1);
    end

    // Timestamp advances on each tick and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ts <= '0;
        else if (tick)
            ts <= ts + TS_W'(1);
    end
endmodule

// File: rtl/pcnt_snapshot.sv
// Shadow register file with an index-selected combinational read port.
// Assumes: live values are from the same clock domain; index NUM_CH is the timestamp.
module pcnt_snapshot #(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          latch_req,
    input  logic [NUM_CH-1:0][DATA_W-1:0] live_cnt,
    input  logic [DATA_W-1:0]             live_ts,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [DATA_W-1:0]             rd_data,
    output logic [NUM_CH-1:0][DATA_W-1:0] shd_cnt,
    output logic [DATA_W-1:0]             shd_ts
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    // Capture every live value on one common strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_cnt <= '0;
            shd_ts  <= '0;
        end else if (latch_req) begin
            shd_cnt <= live_cnt;
            shd_ts  <= live_ts;
        end
    end

    // Select a channel, the timestamp, or zero for out-of-range indices.
    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < NUM_CH)
            rd_data = shd_cnt[rd_idx[CH_W-1:0]];
        else if (32'(rd_idx) == NUM_CH)
            rd_data = shd_ts;
    end
endmodule

// File: rtl/pulse_snap_bank.sv
// Top: NUM_CH edge counters plus timestamp, frozen together into shadows on latch_req.
// Assumes: pulse_in bits are asynchronous; all other inputs are synchronous to clk.
module pulse_snap_bank #(
    parameter int NUM_CH   = 16,
    parameter int DATA_W   = 32,
    parameter int TICK_DIV = 50000,
    parameter int IDX_W    = pcnt_pkg::idx_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pulse_in,
    input  logic              latch_req,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_CH-1:0][DATA_W-1:0] live_cnt;
    logic [NUM_CH-1:0][DATA_W-1:0] shd_cnt;
    logic [DATA_W-1:0]             live_ts;
    logic [DATA_W-1:0]             shd_ts;
    logic                          tick;

    // One counting channel per input bit.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pcnt_edge_chan #(.CNT_W(DATA_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pulse_raw(pulse_in[g]),
            .count    (live_cnt[g])
        );
    end

    pcnt_timebase #(.DIV(TICK_DIV), .TS_W(DATA_W)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .ts   (live_ts)
    );

    pcnt_snapshot #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_req(latch_req),
        .live_cnt (live_cnt),
        .live_ts  (live_ts),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .shd_cnt  (shd_cnt),
        .shd_ts   (shd_ts)
    );
endmodule

// File: rtl/pcnt_checker.sv
// Protocol checker for pulse_snap_bank, attached by bind.
// Assumes: observed signals are the top's internal live and shadow state.
module pcnt_checker #(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          latch_req,
    input logic                          tick,
    input logic [IDX_W-1:0]              rd_idx,
    input logic [DATA_W-1:0]             rd_data,
    input logic [NUM_CH-1:0][DATA_W-1:0] live_cnt,
    input logic [NUM_CH-1:0][DATA_W-1:0] shd_cnt,
    input logic [DATA_W-1:0]             live_ts,
    input logic [DATA_W-1:0]             shd_ts
);
    // R2 and R3: each live count holds or steps by one with wrap.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_step
        p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (live_cnt[g] == $past(live_cnt[g])) ||
            (live_cnt[g] == DATA_W'($past(live_cnt[g]) + DATA_W'(1))))
            else $error("count step violated");
    end

    p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_req |=> ($stable(shd_cnt) && $stable(shd_ts)))
        else $error("shadow changed without latch");

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_req |=> ((shd_cnt == $past(live_cnt)) && (shd_ts == $past(live_ts))))
        else $error("shadow capture mismatch");

    p_ts_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(live_ts))
        else $error("timestamp moved without tick");

    p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (live_ts == DATA_W'($past(live_ts) + DATA_W'(1))))
        else $error("timestamp step wrong");

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> ((live_cnt == '0) && (shd_cnt == '0) && (live_ts == '0) && (shd_ts == '0)))
        else $error("reset did not clear");

    p_read_ts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_idx) == NUM_CH) |-> (rd_data == shd_ts))
        else $error("timestamp read wrong");

    p_read_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_idx) > NUM_CH) |-> (rd_data == '0))
        else $error("out-of-range read not zero");
endmodule

bind pulse_snap_bank pcnt_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_req(latch_req),
    .tick     (tick),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .live_cnt (live_cnt),
    .shd_cnt  (shd_cnt),
    .live_ts  (live_ts),
    .shd_ts   (shd_ts)
);

// File: tb/sim_pulse_snap_bank.sv
module sim_pulse_snap_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 16;
    localparam int DW   = 8;
    localparam int DIV  = 4;
    localparam int IW   = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pulse_in = '0;
    logic           latch_req = 1'b0;
    logic [IW-1:0]  rd_idx = '0;
    logic [DW-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    int exp_cnt [NCH];
    bit done = 0;

    pulse_snap_bank #(.NUM_CH(NCH), .DATA_W(DW), .TICK_DIV(DIV), .IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
        .latch_req(latch_req), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Wrap a model value to the counter width.
    function automatic int wrapv(input int v);
        return v & ((1 << DW) - 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input int idx, output int v);
        rd_idx = IW'(idx);
        #1;
        v = int'(rd_data);
    endtask

    task automatic do_latch();
        @(negedge clk) latch_req = 1'b1;
        @(negedge clk) latch_req = 1'b0;
    endtask

    // Raise the masked inputs for 3 cycles, lower for 3; update the model.
    task automatic pulse(input logic [NCH-1:0] mask);
        @(negedge clk) pulse_in = mask;
        repeat (3) @(negedge clk);
        pulse_in = '0;
        repeat (2) @(negedge clk);
        for (int c = 0; c < NCH; c++)
            if (mask[c]) exp_cnt[c] = wrapv(exp_cnt[c] + 1);
    endtask

    task automatic latch_and_check(input string req);
        int v;
        repeat (4) @(negedge clk);
        do_latch();
        for (int c = 0; c < NCH; c++) begin
            rd(c, v);
            check(req, v, exp_cnt[c]);
        end
    endtask

    initial begin
        int v, a, b;
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < NCH; c++) exp_cnt[c] = 0;
        repeat (5) @(negedge clk);
        // R7: shadows read zero during reset
        rd(0, v);  check("R7 shadow ch0 in reset", v, 0);
        rd(16, v); check("R7 shadow ts in reset", v, 0);
        rst_n = 1'b1;
        // R7/R4: immediate latch sees cleared counters and timestamp
        latch_req = 1'b1;
        @(negedge clk) latch_req = 1'b0;
        rd(16, v); check("R7 ts zero after reset", v, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(c, v); check("R7 count zero after reset", v, 0);
        end

        // R1/R4/R8: random channel patterns
        for (int k = 0; k < 12; k++) begin
            for (int p = 0; p < 3; p++) pulse(NCH'($urandom));
            latch_and_check("R1 random pulses");
        end

        // R9: long high level counts once
        @(negedge clk) pulse_in = NCH'(1 << 5);
        repeat (40) @(negedge clk);
        pulse_in = '0;
        exp_cnt[5] = wrapv(exp_cnt[5] + 1);
        latch_and_check("R9 held level");

        // R4/R5: shadow frozen while live keeps counting
        rd(0, a);
        for (int p = 0; p < 3; p++) pulse('1);
        repeat (4) @(negedge clk);
        rd(0, v); check("R4 shadow held", v, a);
        latch_and_check("R5 counting continued");

        // R3: wrap a channel through all-ones
        for (int p = 0; p < 260; p++) pulse(NCH'(1 << 2));
        latch_and_check("R3 count wrap");

        // R6: tick spacing, short and wrapping windows
        do_latch();
        rd(16, a);
        repeat (39) @(negedge clk);
        latch_req = 1'b1;
        @(negedge clk) latch_req = 1'b0;
        rd(16, b);
        check("R6 ts over 40 cycles", b, wrapv(a + 40 / DIV));
        repeat (1199) @(negedge clk);
        latch_req = 1'b1;
        @(negedge clk) latch_req = 1'b0;
        rd(16, a);
        check("R6 R3 ts wrap over 1200 cycles", a, wrapv(b + 1200 / DIV));

        // R8: indices above the timestamp read zero
        for (int i = NCH + 1; i < (1 << IW); i++) begin
            rd(i, v); check("R8 out-of-range index", v, 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule